// File: doc/BRIEF.md
# Dual-Bank Coefficient Register Interface

This block is the host-facing configuration port of a nine-tap convolver. A host places a 3-bit register address and an 8-bit data byte on its inputs, then pulses a load strobe. The strobe may come from another clock domain; the block synchronizes it and performs exactly one write per strobe. The writes fill a 4-bit configuration register and two banks of nine 8-bit coefficients, and they choose which bank feeds the multipliers.

A bank is filled by strobing nine bytes at that bank's address, and the taps fill in order A through I. The bank select is a separate write. This lets the host refill the idle bank in the background while the other bank drives the datapath. Changing banks replaces all nine coefficients at one clock edge, so no output cycle is lost. The configuration register is broken out as a data-format flag, a 1-D/2-D mode flag and a 2-bit rounding code.

Top module: `coef_bank_if`

## Requirements
- R1: After reset, bank 0 is active, every coefficient in both banks is zero and the configuration register is zero.
- R2: Address 100 writes data bits 3..0 into the configuration register. `fmt_signed` shows bit 0, `mode_2d` shows bit 1 (0 = 1-D, 1 = 2-D) and `rnd_sel` shows bits 3..2.
- R3: Address 010 loads bank 0 and address 011 loads bank 1. Successive strobes at the same bank address fill taps A, B, … I in order. `coef_out` carries tap A in bits 7..0 and tap I in bits 71..64.
- R4: After tap I has been written, the next strobe at the same bank address writes tap A again.
- R5: A write to the other bank's address, to the configuration address, or to either select address makes the next bank load start at tap A.
- R6: Addresses 000, 001 and 111 change no state. This includes coefficients, configuration, active bank and the position in an ongoing bank load.
- R7: Address 101 makes bank 0 active and address 110 makes bank 1 active. All nine outputs change together at a single clock edge.
- R8: Loading the inactive bank leaves `coef_out` unchanged.
- R9: A write takes effect at the third rising clock edge after the strobe rises. Address and data must be held stable until then. A strobe held high for many cycles performs only one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| ld | input | 1 | Load strobe; a write is performed on its rising edge |
| coef_out | output | 72 | Nine active coefficients, tap A in the low byte |
| fmt_signed | output | 1 | Configuration bit 0: data format |
| mode_2d | output | 1 | Configuration bit 1: 1-D or 2-D mode |
| rnd_sel | output | 2 | Configuration bits 3..2: rounding code |
| act_bank | output | 1 | Index of the active bank |

## Verification
A wrong load pointer writes a byte into the wrong lane. That error is seen on `coef_out` only once the affected bank is active, so every test that fills a bank then selects it and compares all nine lanes. A strobe misfired in the synchronizer would make a write land one cycle early or late, or twice. The reference model updates at exactly the third edge after the strobe and is compared on every clock, so such a slip shows within one cycle. Writes to reserved addresses are placed in the middle of a bank load, so a disturbed pointer shows up on the following tap.

// File: rtl/coef_bank_if.sv
module coef_bank_if #(
  parameter int NTAP = 9,
  parameter int CW   = 8,
  parameter int CFGW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         addr,
  input  logic [CW-1:0]      wdata,
  input  logic               ld,
  output logic [NTAP*CW-1:0] coef_out,
  output logic               fmt_signed,
  output logic               mode_2d,
  output logic [1:0]         rnd_sel,
  output logic               act_bank
);
  localparam int PW = $clog2(NTAP);

  logic [2:0]      ld_sync;
  logic [CW-1:0]   bank [2][NTAP];
  logic [CFGW-1:0] cfg;
  logic [PW-1:0]   ptr;
  logic            seq_on, seq_bank;

  wire wr      = ld_sync[1] & ~ld_sync[2];
  wire do_bank = wr && addr[2:1] == 2'b01;
  wire do_cfg  = wr && addr == 3'b100;
  wire do_sel0 = wr && addr == 3'b101;
  wire do_sel1 = wr && addr == 3'b110;

  wire          seq_hit = seq_on && seq_bank == addr[0];
  wire [PW-1:0] idx     = seq_hit ? ptr : '0;
  wire [PW-1:0] idx_nxt = (idx == PW'(NTAP-1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ld_sync <= '0;
    else        ld_sync <= {ld_sync[1:0], ld};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NTAP; i++) bank[b][i] <= '0;
      cfg      <= '0;
      act_bank <= 1'b0;
      ptr      <= '0;
      seq_on   <= 1'b0;
      seq_bank <= 1'b0;
    end else begin
      if (do_bank) begin
        bank[addr[0]][idx] <= wdata;
        ptr      <= idx_nxt;
        seq_on   <= 1'b1;
        seq_bank <= addr[0];
      end else if (do_cfg || do_sel0 || do_sel1) begin
        ptr    <= '0;
        seq_on <= 1'b0;
      end
      if (do_cfg)  cfg      <= wdata[CFGW-1:0];
      if (do_sel0) act_bank <= 1'b0;
      if (do_sel1) act_bank <= 1'b1;
    end
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign coef_out[g*CW +: CW] = bank[act_bank][g];
  end

  assign fmt_signed = cfg[0];
  assign mode_2d    = cfg[1];
  assign rnd_sel    = cfg[3:2];

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'b100) |=> {rnd_sel, mode_2d, fmt_signed} == $past(wdata[CFGW-1:0]));
  // R7
  sel0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'b101) |=> !act_bank);
  // R7
  sel1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'b110) |=> act_bank);
  // R6
  rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr[2:1] == 2'b00 || addr == 3'b111)) |=>
      $stable(coef_out) && $stable(rnd_sel) && $stable(mode_2d) && $stable(fmt_signed) &&
      $stable(act_bank) && $stable(ptr) && $stable(seq_on));
  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PW'(NTAP));
  // R8
  idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr[2:1] == 2'b01 && addr[0] != act_bank) |=> $stable(coef_out));
endmodule

// File: tb/tb_coef_bank_if.sv
module tb_coef_bank_if;
  logic        clk = 0, rst_n = 0, ld = 0;
  logic [2:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [71:0] coef_out;
  logic        fmt_signed, mode_2d, act_bank;
  logic [1:0]  rnd_sel;

  coef_bank_if dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ld(ld),
    .coef_out(coef_out), .fmt_signed(fmt_signed), .mode_2d(mode_2d),
    .rnd_sel(rnd_sel), .act_bank(act_bank));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int mb [2][9];
  int mcfg = 0, mact = 0, mptr = 0, mon = 0, mbank = 0;
  bit chk_en = 0;
  string req = "R1";

  function automatic logic [71:0] exp_coef();
    logic [71:0] v;
    for (int i = 0; i < 9; i++) v[i*8 +: 8] = 8'(mb[mact][i]);
    return v;
  endfunction

  task automatic compare();
    logic [71:0] ec = exp_coef();
    logic [4:0] got = {rnd_sel, mode_2d, fmt_signed, act_bank};
    logic [4:0] exp = {4'(mcfg), 1'(mact)};
    checks++;
    if (coef_out !== ec || got !== exp) begin
      errors++;
      $display("FAIL %s t=%0t coef actual %h expected %h / cfg,act actual %b expected %b",
               req, $time, coef_out, ec, got, exp);
    end
  endtask

  always @(negedge clk) if (chk_en) compare();

  function automatic void apply(input int a, input int d);
    int b, i;
    case (a)
      2, 3: begin
        b = a & 1;
        i = (mon != 0 && mbank == b) ? mptr : 0;
        mb[b][i] = d;
        mptr = (i == 8) ? 0 : i + 1;
        mon = 1; mbank = b;
      end
      4: begin mcfg = d & 15; mon = 0; mptr = 0; end
      5: begin mact = 0; mon = 0; mptr = 0; end
      6: begin mact = 1; mon = 0; mptr = 0; end
      default: ;
    endcase
  endfunction

  task automatic wr(input int a, input int d, input int hold = 0);
    @(negedge clk);
    addr = 3'(a); wdata = 8'(d); ld = 1;
    repeat (3) @(posedge clk);
    apply(a, d);
    repeat (hold + 1) @(negedge clk);
    ld = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 9; i++) mb[b][i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    req = "R1"; chk_en = 1;
    repeat (2) @(negedge clk);

    req = "R2"; wr(4, 8'hFB);
    wr(4, 8'h06);

    req = "R3"; for (int i = 0; i < 9; i++) wr(2, 8'h11 + i * 8'h11);

    req = "R8"; for (int i = 0; i < 9; i++) wr(3, 8'h80 + i);

    req = "R7"; wr(6, 0);
    wr(5, 0);
    wr(6, 0);

    req = "R4"; wr(4, 8'h09);
    for (int i = 0; i < 10; i++) wr(3, 8'hA0 + i);
    wr(3, 8'h55);

    req = "R5"; wr(2, 8'h01);
    wr(3, 8'h66);
    wr(3, 8'h67);
    wr(5, 0);
    wr(3, 8'h70);
    wr(6, 0);
    wr(3, 8'h71);

    req = "R6"; wr(0, 8'hFF);
    wr(1, 8'hEE);
    wr(7, 8'hDD);
    wr(3, 8'h72);

    req = "R9"; wr(3, 8'h3C, 8);
    wr(4, 8'h0F, 5);
    wr(3, 8'h3D);

    chk_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule